// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a bank of general-purpose pins controlled through a small memory-mapped register bus. Software programs the output value and the output enable for each pin, and reads back the pin levels after they have been synchronized. Each pin can also serve as an interrupt source. A select bit makes a pin eligible. Two configuration bits choose whether the pin reacts to a level or to an edge, and whether it reacts to high/rising or to low/falling. A detected condition latches a sticky status bit. The single interrupt output is raised whenever any status bit is set together with its enable bit.

Every register occupies a 16-byte slot and has three write views. A plain write replaces the whole word. A set view ORs in the bits written as 1. A clear view removes the bits written as 1. With these views, software can change single pins without a read-modify-write, and can acknowledge individual status bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is low, every register reads 0, `pin_out` and `pin_oe` are 0, and `irq` is 0.
- R2: A write at slot offset 0x0 replaces the whole register. A read at offset 0x0, 0x4 or 0x8 of the slot returns the register value. Slot bases: 0x00 output data, 0x10 input data, 0x20 output enable, 0x30 interrupt select, 0x40 interrupt enable, 0x50 level mode, 0x60 polarity, 0x70 status.
- R3: A write at slot offset 0x4 sets each bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write at slot offset 0x8 clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R5: The input-data slot returns the pin inputs delayed by two clock edges, and writes to it have no effect.
- R6: `pin_oe` equals the output-enable register, and `pin_out` equals the output data ANDed with the output enable.
- R7: A pin whose level bit is 0 sets its status bit on an edge of the synchronized input: a rising edge when polarity is 1, a falling edge when polarity is 0. The status bit then stays set until it is cleared. The combined code {polarity, level} is 0 falling, 1 low, 2 rising, 3 high.
- R8: A pin whose level bit is 1 sets its status bit while the synchronized input equals its polarity bit. If the level is still active, the status bit is set again right after a clear.
- R9: A pin whose select bit is 0 never sets its status bit by detection.
- R10: `irq` is 1 exactly when some pin has both its status bit and its enable bit set.
- R11: When a detected event and a clear-view write hit the same status bit in the same cycle, the bit stays 1.
- R12: A write at slot offset 0xC changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address: slot in bits 6:4, write view in bits 3:2 |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data of the addressed register (combinational) |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data gated by output enable |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The case that is hardest to produce from the ports is a clear write to the status register landing in exactly the same cycle as a detected event on the same bit. Edges last only a single cycle and pass through a two-stage synchronizer, so hitting one by timing is fragile. The bench instead uses level-triggered pins held at their active level. Such a pin has an event present in every cycle, so every clear-all write coincides with one. Because the bench gives each pin one of the four trigger codes by pin index, a single clear exercises the competing case on the level pins and a plain clear on the edge pins at the same time.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int NUM_SLOTS = 8;

   typedef enum logic [2:0] {
      SLOT_DOUT = 3'd0,
      SLOT_DIN  = 3'd1,
      SLOT_DOE  = 3'd2,
      SLOT_SEL  = 3'd3,
      SLOT_EN   = 3'd4,
      SLOT_LEV  = 3'd5,
      SLOT_POL  = 3'd6,
      SLOT_STAT = 3'd7
   } slot_e;

   typedef enum logic [1:0] {
      VIEW_WRITE = 2'd0,
      VIEW_SET   = 2'd1,
      VIEW_CLR   = 2'd2,
      VIEW_NONE  = 2'd3
   } view_e;

endpackage

// File: rtl/gpio_reg_word.sv
module gpio_reg_word
   import gpio_bank_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  view_e        view,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] evt,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = q;
      if (wr_en) begin
         case (view)
            VIEW_WRITE: nxt = wdata;
            VIEW_SET:   nxt = q | wdata;
            VIEW_CLR:   nxt = q & ~wdata;
            default:    nxt = q;
         endcase
      end
      // detection has priority over clearing
      nxt = nxt | evt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int N      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] sel,
   input  logic [N-1:0] lev_mode,
   input  logic [N-1:0] pol,
   output logic [N-1:0] evt
);
   logic [N-1:0] prev;
   logic [N-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl;
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      always_comb begin
         case ({pol[i], lev_mode[i]})
            2'b00:   hit[i] = ~lvl[i] & prev[i];  // falling edge
            2'b01:   hit[i] = ~lvl[i];            // low level
            2'b10:   hit[i] = lvl[i] & ~prev[i];  // rising edge
            default: hit[i] = lvl[i];             // high level
         endcase
      end
   end

   assign evt = hit & sel;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $fatal(1, "NPINS must be 1..32");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $fatal(1, "ADDR_W must be at least 8");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be 1..3");
   end

   logic              addr_ok;
   slot_e             slot;
   view_e             view;
   logic [NPINS-1:0]  word  [NUM_SLOTS];
   logic [NPINS-1:0]  din_q;
   logic [NPINS-1:0]  evt;

   assign addr_ok = (bus_addr >> 7) == '0;
   assign slot    = slot_e'(bus_addr[6:4]);
   assign view    = view_e'(bus_addr[3:2]);

   gpio_in_sync #(.N(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_q)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (s == int'(SLOT_DIN)) begin : g_ro
         assign word[s] = din_q;
      end else begin : g_rw
         logic [NPINS-1:0] slot_evt;
         if (s == int'(SLOT_STAT)) begin : g_stat
            assign slot_evt = evt;
         end else begin : g_plain
            assign slot_evt = '0;
         end
         gpio_reg_word #(.W(NPINS)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_we && addr_ok && (slot == slot_e'(s))),
            .view  (view),
            .wdata (bus_wdata),
            .evt   (slot_evt),
            .q     (word[s])
         );
      end
   end

   logic [NPINS-1:0] stat_q, sel_q, en_q;
   assign stat_q = word[SLOT_STAT];
   assign sel_q  = word[SLOT_SEL];
   assign en_q   = word[SLOT_EN];

   gpio_detect #(.N(NPINS)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (din_q),
      .sel      (sel_q),
      .lev_mode (word[SLOT_LEV]),
      .pol      (word[SLOT_POL]),
      .evt      (evt)
   );

   assign bus_rdata = addr_ok ? word[slot] : '0;
   assign pin_oe    = word[SLOT_DOE];
   assign pin_out   = word[SLOT_DOUT] & word[SLOT_DOE];
   assign irq       = |(stat_q & en_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [NPINS-1:0] pin_in,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] din,
   input logic [NPINS-1:0] stat,
   input logic [NPINS-1:0] sel,
   input logic             irq
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3) since_rst <= since_rst + 2'd1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (stat == '0 && pin_oe == '0 && !irq));

   assert_din_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(since_rst) >= SYNC_STAGES) |-> (din == $past(pin_in, SYNC_STAGES)));

   assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we) |-> (($past(stat) & ~stat) == '0));

   assert_no_unselected_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we) |-> ((stat & ~$past(stat) & ~$past(sel)) == '0));

   assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(bus_we) || stat != $past(stat)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .bus_we (bus_we),
   .pin_in (pin_in),
   .pin_oe (pin_oe),
   .din    (din_q),
   .stat   (stat_q),
   .sel    (sel_q),
   .irq    (irq)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   gpio_irq_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] p;
      logic [31:0] exp;

      // R1: reset state
      idle(2);
      for (int s = 0; s < 8; s++) begin
         rd(8'(s * 16), v);
         check("R1 reset read", v, 32'h0);
      end
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 pin_oe", pin_oe, 32'h0);
      check("R1 pin_out", pin_out, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R2/R3/R4/R12 sweep over every writable slot
      for (int s = 0; s < 8; s++) begin
         if (s == 1) continue;
         p = 32'h5A5A_1234 ^ (32'h0101_0101 * s);
         wr(8'(s * 16), p);
         for (int vw = 0; vw < 3; vw++) begin
            rd(8'(s * 16 + vw * 4), v);
            check("R2 alias read", v, p);
         end
         wr(8'(s * 16 + 4), 32'h0000_FF00);
         exp = p | 32'h0000_FF00;
         rd(8'(s * 16), v);
         check("R3 set view", v, exp);
         wr(8'(s * 16 + 8), 32'h1200_00F0);
         exp = exp & ~32'h1200_00F0;
         rd(8'(s * 16), v);
         check("R4 clear view", v, exp);
         wr(8'(s * 16 + 12), 32'hFFFF_FFFF);
         rd(8'(s * 16), v);
         check("R12 offset C ignored", v, exp);
         wr(8'(s * 16), 32'h0);
      end

      // R5: input data path and read-only behaviour
      @(negedge clk);
      pin_in = 32'hA5C3_0F96;
      idle(3);
      rd(8'h10, v);
      check("R5 din value", v, 32'hA5C3_0F96);
      wr(8'h10, 32'h0);
      rd(8'h10, v);
      check("R5 din write ignored", v, 32'hA5C3_0F96);
      pin_in = 32'h0;
      idle(3);

      // R6: output gating
      wr(8'h00, 32'hF0F0_1234);
      wr(8'h20, 32'hFF00_FF00);
      check("R6 pin_out", pin_out, 32'hF000_1200);
      check("R6 pin_oe", pin_oe, 32'hFF00_FF00);
      wr(8'h00, 32'h0);
      wr(8'h20, 32'h0);

      // pin i uses code i%4: 0 fall, 1 low, 2 rise, 3 high
      wr(8'h50, 32'hAAAA_AAAA);
      wr(8'h60, 32'hCCCC_CCCC);
      wr(8'h78, 32'hFFFF_FFFF);
      wr(8'h30, 32'hFFFF_FFFF);
      idle(1);
      rd(8'h70, v);
      check("R8 low level sets", v, 32'h2222_2222);
      wr(8'h78, 32'hFFFF_FFFF);
      rd(8'h70, v);
      check("R11 event beats clear", v, 32'h2222_2222);

      // rising edge and high level
      pin_in = 32'hFFFF_FFFF;
      idle(4);
      rd(8'h70, v);
      check("R7 rising plus R8 high", v, 32'hEEEE_EEEE);
      idle(5);
      rd(8'h70, v);
      check("R7 edge status sticky", v, 32'hEEEE_EEEE);
      wr(8'h78, 32'hFFFF_FFFF);
      rd(8'h70, v);
      check("R8 high level reasserts", v, 32'h8888_8888);

      // falling edge and low level
      pin_in = 32'h0;
      idle(4);
      rd(8'h70, v);
      check("R7 falling plus R8 low", v, 32'hBBBB_BBBB);
      wr(8'h78, 32'hFFFF_FFFF);
      rd(8'h70, v);
      check("R8 low level reasserts", v, 32'h2222_2222);

      // R10: combined interrupt
      check("R10 irq off with no enables", {31'b0, irq}, 32'h0);
      wr(8'h40, 32'h0000_0002);
      check("R10 irq on", {31'b0, irq}, 32'h1);
      wr(8'h40, 32'h0000_0001);
      check("R10 irq off", {31'b0, irq}, 32'h0);
      wr(8'h44, 32'h2000_0000);
      check("R10 irq on upper pin", {31'b0, irq}, 32'h1);
      wr(8'h40, 32'h0);

      // R9: upper half unselected
      wr(8'h30, 32'h0000_FFFF);
      wr(8'h78, 32'hFFFF_FFFF);
      rd(8'h70, v);
      check("R9 unselected low level idle", v, 32'h0000_2222);
      pin_in = 32'hFFFF_FFFF;
      idle(4);
      rd(8'h70, v);
      check("R9 unselected edges ignored", v, 32'h0000_EEEE);
      wr(8'h30, 32'h0);
      wr(8'h78, 32'hFFFF_FFFF);
      pin_in = 32'h0;
      idle(4);
      rd(8'h70, v);
      check("R9 nothing selected", v, 32'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog R1..all actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule